// File: doc/BRIEF.md
# GPIO Companion Register Block

This block is a small peripheral register file reached over a single-cycle memory-mapped bus. Each access carries a byte address, and only its six lowest bits select a register. Most registers are plain 16-bit storage for mode, clock division, clock control and interrupt bookkeeping. Interrupt registers here only store values and raise no interrupt. There is also a power register that forces extra bits, and a fixed, read-only status word.

Next to the registers sits a 16-line general-purpose I/O bank. It has one direction bit per line and a level register that is shared by inputs and outputs. External input lines can set or clear level bits at any time. The output pins only move when software writes the direction register or the level register. On such a write, each output pin whose value changes raises a one-cycle change strobe, so a neighbouring block can react to individual line transitions.

Top module: `gpio_ctl_regs`

## Requirements
- R1: Only bus address bits [5:0] select a register. Addresses that differ only above bit 5 reach the same register.
- R2: The offsets 0x00 (mode), 0x04 (divider), 0x10 (clock control), 0x14 (interrupt request), 0x18 (interrupt mask) and 0x1C (interrupt status) each store the low 16 bits of the write data and return them on read. After reset they read 0.
- R3: A write to offset 0x0C (power) stores the low 16 bits of the write data. When bit 7 of that data is 1, bits 15 and 6 of the stored value are also set (OR with 0x8040).
- R4: Offset 0x08 (status) always reads 0x0002, and writes to it change nothing.
- R5: A write to offset 0x24 or 0x28 stores (write data AND direction register) into the level register. Reads of either offset return the level register. Offset 0x20 holds the direction register, where 1 means output.
- R6: `pin_out` equals level AND direction as computed at the most recent write to offset 0x20, 0x24 or 0x28. It appears in the cycle after that write and does not change otherwise.
- R7: In the cycle after a write to offset 0x20, 0x24 or 0x28, `pin_chg` shows, for one cycle, the bits in which the new `pin_out` differs from the old one. In every other cycle it is 0.
- R8: When `ext_we[i]` is 1, level bit i takes the value of `ext_val[i]`, whatever the direction bit. This alone does not move `pin_out` or `pin_chg`.
- R9: If a bus write to offset 0x24 or 0x28 happens in the same cycle as an external update, the bus write decides the level register and the external update is dropped.
- R10: Reads of any other offset (for example 0x01, 0x2C, 0x3C) return 0. Writes to those offsets change no register and no output.
- R11: `bus_rdata` is registered. It holds the addressed value in the cycle after `bus_rd` and 0 after a cycle without a read. A read in the same cycle as a write returns the value from before the write. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address; bits [5:0] decoded |
| bus_wdata | input | BUS_W (32) | Write data; low 16 bits used |
| bus_rdata | output | DATA_W (16) | Registered read data |
| ext_we | input | NUM_LINES (16) | Per-line external level update enable |
| ext_val | input | NUM_LINES (16) | Per-line external level value |
| pin_out | output | NUM_LINES (16) | Output pin levels |
| pin_chg | output | NUM_LINES (16) | One-cycle per-line change strobes |

## Verification
The bench goes after the masking order on the level register. It writes the level register while the direction is zero, then widens the direction. A design that masked at the output and not at store time would put the stale level bits on the pins. External updates are applied to lines configured as outputs and then read back. If the pins move at that point, the design re-evaluates the outputs when it should not, and that shows up as a stray strobe. A level write collides with an external update in the same cycle, which exposes a reversed priority. Reads of aliased, unaligned and unused addresses, the power bit-7 forcing, and a status write catch decode holes and a writable status word. A long random phase then compares every output each cycle against the behavioural model.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  localparam int unsigned OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
  localparam logic [OFS_W-1:0] OFS_CDIV = 6'h04;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h08;
  localparam logic [OFS_W-1:0] OFS_PWR  = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_CCTL = 6'h10;
  localparam logic [OFS_W-1:0] OFS_IREQ = 6'h14;
  localparam logic [OFS_W-1:0] OFS_IMSK = 6'h18;
  localparam logic [OFS_W-1:0] OFS_ISTA = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_DIR  = 6'h20;
  localparam logic [OFS_W-1:0] OFS_LVLW = 6'h24;
  localparam logic [OFS_W-1:0] OFS_LVLR = 6'h28;

  localparam int unsigned NUM_PLAIN = 6;

  // one-hot register selection derived from the low address bits
  typedef struct packed {
    logic [NUM_PLAIN-1:0] plain; // ista, imsk, ireq, cctl, cdiv, mode
    logic                 stat;
    logic                 pwr;
    logic                 dir;
    logic                 lvl;
  } gcr_sel_t;

endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output gcr_sel_t         sel
);

  always_comb begin
    sel = '0;
    case (ofs)
      OFS_MODE: sel.plain[0] = 1'b1;
      OFS_CDIV: sel.plain[1] = 1'b1;
      OFS_CCTL: sel.plain[2] = 1'b1;
      OFS_IREQ: sel.plain[3] = 1'b1;
      OFS_IMSK: sel.plain[4] = 1'b1;
      OFS_ISTA: sel.plain[5] = 1'b1;
      OFS_STAT: sel.stat     = 1'b1;
      OFS_PWR:  sel.pwr      = 1'b1;
      OFS_DIR:  sel.dir      = 1'b1;
      OFS_LVLW,
      OFS_LVLR: sel.lvl      = 1'b1;
      default:  sel = '0;
    endcase
  end

endmodule

// File: rtl/gcr_ctrl_regs.sv
module gcr_ctrl_regs
  import gcr_pkg::*;
#(
  parameter int unsigned     DATA_W    = 16,
  parameter int unsigned     PWR_TRIG  = 7,
  parameter logic [DATA_W-1:0] PWR_FORCE = 16'h8040
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  gcr_sel_t                        sel,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q,
  output logic [DATA_W-1:0]               pwr_q
);

  // plain storage: one register per selectable slot
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)                      plain_q[g] <= '0;
      else if (wr && sel.plain[g])  plain_q[g] <= wdata;
    end
  end

  logic [DATA_W-1:0] pwr_d;
  always_comb begin
    pwr_d = wdata;
    if (wdata[PWR_TRIG]) pwr_d = wdata | PWR_FORCE;
  end

  always_ff @(posedge clk) begin
    if (rst)                pwr_q <= '0;
    else if (wr && sel.pwr) pwr_q <= pwr_d;
  end

endmodule

// File: rtl/gcr_gpio_bank.sv
module gcr_gpio_bank #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_dir,
  input  logic                 wr_lvl,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] ext_we,
  input  logic [NUM_LINES-1:0] ext_val,
  output logic [NUM_LINES-1:0] dir_q,
  output logic [NUM_LINES-1:0] lvl_q,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_chg
);

  logic [NUM_LINES-1:0] dir_d, lvl_d, out_d;
  logic                 reeval;

  always_comb begin
    dir_d = wr_dir ? wdata : dir_q;
    lvl_d = lvl_q;
    if (wr_lvl) begin
      lvl_d = wdata & dir_q;          // bus write wins over external lines
    end else begin
      for (int i = 0; i < NUM_LINES; i++)
        if (ext_we[i]) lvl_d[i] = ext_val[i];
    end
    out_d  = lvl_d & dir_d;
    reeval = wr_dir | wr_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      lvl_q   <= '0;
      pin_out <= '0;
      pin_chg <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
      if (reeval) begin
        pin_chg <= out_d ^ pin_out;   // pin_out doubles as the previous value
        pin_out <= out_d;
      end else begin
        pin_chg <= '0;
      end
    end
  end

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gcr_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter int unsigned       BUS_W      = 32,
  parameter int unsigned       DATA_W     = 16,
  parameter int unsigned       NUM_LINES  = 16,
  parameter logic [DATA_W-1:0] STATUS_RST = 16'h0002
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] ext_we,
  input  logic [NUM_LINES-1:0] ext_val,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_chg
);

  localparam int unsigned HI_A = ADDR_W - OFS_W;
  localparam int unsigned HI_D = BUS_W - DATA_W;

  logic [DATA_W-1:0] wd;
  logic              unused_hi;
  assign wd        = bus_wdata[DATA_W-1:0];
  assign unused_hi = ^{bus_addr[OFS_W +: HI_A], bus_wdata[DATA_W +: HI_D]};

  gcr_sel_t sel;
  gcr_decode u_dec (
    .ofs (bus_addr[OFS_W-1:0]),
    .sel (sel)
  );

  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [DATA_W-1:0]                pwr_q;

  gcr_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .sel     (sel),
    .wdata   (wd),
    .plain_q (plain_q),
    .pwr_q   (pwr_q)
  );

  logic [NUM_LINES-1:0] dir_q, lvl_q;

  gcr_gpio_bank #(.NUM_LINES(NUM_LINES)) u_gpio (
    .clk     (clk),
    .rst     (rst),
    .wr_dir  (bus_wr && sel.dir),
    .wr_lvl  (bus_wr && sel.lvl),
    .wdata   (wd[NUM_LINES-1:0]),
    .ext_we  (ext_we),
    .ext_val (ext_val),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .pin_out (pin_out),
    .pin_chg (pin_chg)
  );

  // read mux over the one-hot selection
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_PLAIN; k++)
      if (sel.plain[k]) rd_val = plain_q[k];
    if (sel.stat) rd_val = STATUS_RST;
    if (sel.pwr)  rd_val = pwr_q;
    if (sel.dir)  rd_val = DATA_W'(dir_q);
    if (sel.lvl)  rd_val = DATA_W'(lvl_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/gcr_checker.sv
module gcr_checker #(
  parameter int unsigned       ADDR_W     = 12,
  parameter int unsigned       DATA_W     = 16,
  parameter int unsigned       NUM_LINES  = 16,
  parameter logic [DATA_W-1:0] STATUS_RST = 16'h0002
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] pin_out,
  input logic [NUM_LINES-1:0] pin_chg
);

  logic [5:0] ofs;
  logic       gpio_wr, known;
  assign ofs     = bus_addr[5:0];
  assign gpio_wr = bus_wr && (ofs == 6'h20 || ofs == 6'h24 || ofs == 6'h28);
  assign known   = (ofs[1:0] == 2'b00) && (ofs <= 6'h28);

  p_chg_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_chg != '0) |-> $past(gpio_wr));

  p_chg_is_diff_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pin_chg == (pin_out ^ $past(pin_out))));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(gpio_wr)) |-> $stable(pin_out));

  p_status_const_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd) && ($past(ofs) == 6'h08)) |-> (bus_rdata == STATUS_RST));

  p_undecoded_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_rd) && !$past(known)) |-> (bus_rdata == '0));

  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_rd)) |-> (bus_rdata == '0));

endmodule

bind gpio_ctl_regs gcr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .STATUS_RST(STATUS_RST)
) i_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_chg(pin_chg)
);

// File: tb/test_gpio_ctl_regs.sv
`timescale 1ns/1ps
module test_gpio_ctl_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] ext_we = '0, ext_val = '0;
  logic [15:0] pin_out, pin_chg;

  always #2 clk = ~clk;

  gpio_ctl_regs i_gpio_ctl_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_we(ext_we), .ext_val(ext_val),
    .pin_out(pin_out), .pin_chg(pin_chg)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R11";
  bit    done = 0;

  // behavioural reference model
  logic [15:0] m_plain [16];
  logic [15:0] m_pwr, m_dir, m_lvl, m_out, m_chg, m_rd;

  function automatic logic [15:0] mread(logic [5:0] o);
    case (o)
      6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C: return m_plain[o[5:2]];
      6'h08: return 16'h0002;
      6'h0C: return m_pwr;
      6'h20: return m_dir;
      6'h24, 6'h28: return m_lvl;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step();
    logic [5:0]  o = bus_addr[5:0];
    logic [15:0] w = bus_wdata[15:0];
    logic [15:0] nl = m_lvl, nd = m_dir, no;
    logic        lvl_wr, trig;
    if (rst) begin
      foreach (m_plain[i]) m_plain[i] = '0;
      m_pwr = 0; m_dir = 0; m_lvl = 0; m_out = 0; m_chg = 0; m_rd = 0;
      return;
    end
    m_rd   = bus_rd ? mread(o) : 16'h0;
    lvl_wr = bus_wr && (o == 6'h24 || o == 6'h28);
    trig   = lvl_wr || (bus_wr && o == 6'h20);
    if (bus_wr) begin
      case (o)
        6'h00, 6'h04, 6'h10, 6'h14, 6'h18, 6'h1C: m_plain[o[5:2]] = w;
        6'h0C: m_pwr = w[7] ? (w | 16'h8040) : w;
        6'h20: nd = w;
        6'h24, 6'h28: nl = w & m_dir;
        default: ;
      endcase
    end
    if (!lvl_wr)
      for (int i = 0; i < 16; i++) if (ext_we[i]) nl[i] = ext_val[i];
    m_dir = nd; m_lvl = nl;
    if (trig) begin
      no = nl & nd; m_chg = no ^ m_out; m_out = no;
    end else m_chg = 0;
  endtask

  task automatic check16(string req, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check16(cur_req, "pin_out", pin_out, m_out);
    check16(cur_req, "pin_chg", pin_chg, m_chg);
    check16(cur_req, "bus_rdata", bus_rdata, m_rd);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 0;
  endtask

  task automatic rd_exp(logic [11:0] a, logic [15:0] exp, string req);
    bus_rd = 1; bus_addr = a; cyc(); bus_rd = 0;
    check16(req, "read value", bus_rdata, exp);
  endtask

  task automatic ext(logic [15:0] we, logic [15:0] v);
    ext_we = we; ext_val = v; cyc(); ext_we = 0; ext_val = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    cur_req = "R11";
    check16("R11", "reset pin_out", pin_out, 16'h0);
    check16("R11", "reset rdata", bus_rdata, 16'h0);
    rd_exp(12'h000, 16'h0, "R2");

    cur_req = "R4";
    rd_exp(12'h008, 16'h0002, "R4");
    wr(12'h008, 32'h0000_FFFF);
    rd_exp(12'h008, 16'h0002, "R4");

    cur_req = "R2";
    wr(12'h000, 32'h1234_5678); rd_exp(12'h000, 16'h5678, "R2");
    wr(12'h010, 32'h0000_00C3); rd_exp(12'h010, 16'h00C3, "R2");
    wr(12'h014, 32'h0000_A5A5); rd_exp(12'h014, 16'hA5A5, "R2");
    wr(12'h018, 32'hFFFF_0F0F); rd_exp(12'h018, 16'h0F0F, "R2");
    wr(12'h01C, 32'h0000_1111); rd_exp(12'h01C, 16'h1111, "R2");

    cur_req = "R1";
    wr(12'h044, 32'h0000_BEEF);
    rd_exp(12'h004, 16'hBEEF, "R1");
    rd_exp(12'hF84, 16'hBEEF, "R1");

    cur_req = "R3";
    wr(12'h00C, 32'h0000_0080); rd_exp(12'h00C, 16'h80C0, "R3");
    wr(12'h00C, 32'h0000_0001); rd_exp(12'h00C, 16'h0001, "R3");
    wr(12'h00C, 32'h0000_7F7F); rd_exp(12'h00C, 16'h7F7F, "R3");
    wr(12'h00C, 32'h0000_0280); rd_exp(12'h00C, 16'h82C0, "R3");

    cur_req = "R11";
    bus_rd = 1; bus_wr = 1; bus_addr = 12'h000; bus_wdata = 32'h0000_9999;
    cyc(); bus_rd = 0; bus_wr = 0;
    check16("R11", "read-during-write old value", bus_rdata, 16'h5678);

    cur_req = "R5";
    wr(12'h024, 32'h0000_FFFF);
    check16("R5", "pins after masked level write", pin_out, 16'h0);
    rd_exp(12'h028, 16'h0000, "R5");
    wr(12'h020, 32'h0000_00FF);
    check16("R6", "pins after dir write", pin_out, 16'h0);
    check16("R7", "no strobe without change", pin_chg, 16'h0);

    cur_req = "R8";
    ext(16'hFFFF, 16'hF0F0);
    check16("R8", "pins unchanged by ext", pin_out, 16'h0);
    check16("R8", "no strobe from ext", pin_chg, 16'h0);
    rd_exp(12'h028, 16'hF0F0, "R8");
    rd_exp(12'h024, 16'hF0F0, "R5");

    cur_req = "R6";
    wr(12'h020, 32'h0000_00FF);
    check16("R6", "pins after dir rewrite", pin_out, 16'h00F0);
    check16("R7", "strobe on change", pin_chg, 16'h00F0);
    cyc();
    check16("R7", "strobe lasts one cycle", pin_chg, 16'h0);
    wr(12'h028, 32'h0000_AAAA);
    check16("R5", "level write via read offset", pin_out, 16'h00AA);
    check16("R7", "strobe diff", pin_chg, 16'h005A);
    rd_exp(12'h020, 16'h00FF, "R5");

    cur_req = "R9";
    bus_wr = 1; bus_addr = 12'h024; bus_wdata = 32'h0000_000F;
    ext_we = 16'h00F0; ext_val = 16'h00F0;
    cyc(); bus_wr = 0; ext_we = 0; ext_val = 0;
    check16("R9", "bus write wins", pin_out, 16'h000F);
    rd_exp(12'h024, 16'h000F, "R9");

    cur_req = "R10";
    rd_exp(12'h02C, 16'h0, "R10");
    rd_exp(12'h03C, 16'h0, "R10");
    rd_exp(12'h001, 16'h0, "R10");
    wr(12'h02C, 32'h0000_FFFF);
    wr(12'h001, 32'h0000_FFFF);
    check16("R10", "pins after undecoded write", pin_out, 16'h000F);
    rd_exp(12'h000, 16'h9999, "R10");
    rd_exp(12'h024, 16'h000F, "R10");

    cur_req = "R7";
    for (int n = 0; n < 400; n++) begin
      logic [5:0] offs [14] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18,
                               6'h1C, 6'h20, 6'h24, 6'h28, 6'h2C, 6'h20, 6'h24};
      bus_wr    = ($urandom % 3) == 0;
      bus_rd    = ($urandom % 2) == 0;
      bus_addr  = {6'($urandom), offs[$urandom % 14]};
      bus_wdata = $urandom;
      ext_we    = (($urandom % 2) == 0) ? 16'($urandom) : 16'h0;
      ext_val   = 16'($urandom);
      cyc();
    end
    bus_wr = 0; bus_rd = 0; ext_we = 0;
    cyc();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule